// File: doc/BRIEF.md
# Frame-Tagged Serial Data FIFO Pair

This block is the data port of a synchronous serial frame link. On the transmit side, a bus writer pushes bytes into a small FIFO. The serializer drains that FIFO through a valid/ready handshake. On the receive side, the deserializer stores each incoming byte together with three tags: end of frame, CRC mismatch and receiver overrun. Each byte and its tags form one 11-bit entry.

A register read takes the oldest receive entry. The read data holds only its byte. The entry's three tags are shown on dedicated status outputs for as long as that entry is at the bottom of the FIFO. When the FIFO is full, an incoming byte is dropped and the loss is recorded as a tag on the last entry that was kept, so software learns of the gap at the right point in the byte stream.

Each direction has an enable input. While an enable is low, its FIFO is held empty.

Top module: `framed_fifo_port`

## Requirements
- R1: Each accepted write appends `wr_data` to the transmit FIFO. `tx_valid` is high while the FIFO holds data and `tx_en` is 1. Bytes leave in write order, one per cycle in which `tx_valid` and `tx_ready` are both high. While not taken, `tx_data` holds its value.
- R2: `tx_full` is high when 8 bytes (TX_DEPTH) are held. A write while `tx_full` is high is dropped, even if a byte is taken in the same cycle. In the cycle after such a write, `wr_err` is 1 for exactly one cycle.
- R3: While `tx_en` is 0, the transmit FIFO becomes empty on the next clock and stays empty. Writes in that state are ignored and raise no `wr_err`.
- R4: A receive entry is formed from the incoming signals as follows: bits 7..0 are `rx_byte`, bit 8 is `rx_eof`, bit 9 is `rx_crc_err` and bit 10 is the overrun tag. `rd_data` shows bits 7..0 of the bottom entry. A cycle with `rd_en` high removes that entry. Entries leave in arrival order.
- R5: While the receive FIFO is not empty, `st_eof`, `st_crc` and `st_ovr` equal bits 8, 9 and 10 of the bottom entry. They follow each new bottom entry after a read.
- R6: `rx_full` is high when 12 entries (RX_DEPTH) are held. A push while `rx_full` is high discards the byte and sets bit 10 of the most recently stored entry. This also applies when a read happens in the same cycle.
- R7: Reading an empty receive FIFO returns `rd_data` = 0 and changes nothing. While the receive FIFO is empty, all three status tags are 0.
- R8: While `rx_en` is 0, the receive FIFO becomes empty on the next clock and stays empty. Pushes in that state are ignored.
- R9: After reset, both FIFOs are empty, `tx_valid` and `wr_err` are 0, and `rd_data` and the status tags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; low flushes the transmit FIFO |
| rx_en | input | 1 | Receive enable; low flushes the receive FIFO |
| wr_en | input | 1 | Register write strobe for the transmit FIFO |
| wr_data | input | 8 | Byte to append to the transmit FIFO |
| wr_err | output | 1 | One-cycle pulse after a write was dropped because the FIFO was full |
| tx_valid | output | 1 | Transmit byte available to the serializer |
| tx_ready | input | 1 | Serializer takes the byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_push | input | 1 | Deserializer stores a byte |
| rx_byte | input | 8 | Received byte |
| rx_eof | input | 1 | Byte is the last one of its frame |
| rx_crc_err | input | 1 | CRC check failed for the frame |
| rd_en | input | 1 | Register read strobe; removes the bottom receive entry |
| rd_data | output | 8 | Byte of the bottom receive entry, 0 when empty |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| st_eof | output | 1 | End-of-frame tag of the bottom entry |
| st_crc | output | 1 | CRC error tag of the bottom entry |
| st_ovr | output | 1 | Overrun tag of the bottom entry |

## Verification
Two functions can fall in the same cycle: a receive push that arrives while the FIFO is full, and a register read that frees a slot. The bench provokes this by filling all twelve entries and then raising `rx_push` and `rd_en` together. It then judges that the byte was dropped, that the tail entry carries the overrun tag when it later reaches the bottom, and that the read still returned the old head. The transmit side gets the same treatment: a write to a full FIFO is issued in the cycle the serializer takes a byte, and the bench checks that the write raised `wr_err` and that only the old bytes leave.

// File: rtl/framed_fifo_port.sv
module framed_fifo_port #(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 12,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          rx_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_err,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_full,
  output logic          tx_empty,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_eof,
  input  logic          rx_crc_err,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rx_full,
  output logic          rx_empty,
  output logic          st_eof,
  output logic          st_crc,
  output logic          st_ovr
);
  localparam int TAW = (TX_DEPTH > 1) ? $clog2(TX_DEPTH) : 1;
  localparam int RAW = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
  localparam int EW  = DW + 3;
  localparam int B_OVR = DW + 2;

  logic [DW-1:0]  tmem [TX_DEPTH];
  logic [TAW-1:0] twp, trp;
  logic [TAW:0]   tcnt;

  assign tx_full  = (tcnt == (TAW+1)'(TX_DEPTH));
  assign tx_empty = (tcnt == '0);
  assign tx_valid = tx_en && !tx_empty;
  assign tx_data  = tmem[trp];

  wire tpush = tx_en && wr_en && !tx_full;
  wire tpop  = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      twp <= '0; trp <= '0; tcnt <= '0; wr_err <= 1'b0;
    end else begin
      wr_err <= tx_en && wr_en && tx_full;
      if (!tx_en) begin
        twp <= '0; trp <= '0; tcnt <= '0;
      end else begin
        if (tpush) twp <= (twp == TAW'(TX_DEPTH-1)) ? '0 : twp + 1'b1;
        if (tpop)  trp <= (trp == TAW'(TX_DEPTH-1)) ? '0 : trp + 1'b1;
        tcnt <= tcnt + (TAW+1)'(tpush) - (TAW+1)'(tpop);
      end
    end
  end

  always_ff @(posedge clk)
    if (tpush) tmem[twp] <= wr_data;

  logic [EW-1:0]  rmem [RX_DEPTH];
  logic [RAW-1:0] rwp, rrp, rlast;
  logic [RAW:0]   rcnt;
  logic [EW-1:0]  head;

  assign rx_full  = (rcnt == (RAW+1)'(RX_DEPTH));
  assign rx_empty = (rcnt == '0);
  assign head     = rmem[rrp];
  assign rlast    = (rwp == '0) ? RAW'(RX_DEPTH-1) : rwp - 1'b1;

  wire rpush = rx_en && rx_push && !rx_full;
  wire rovr  = rx_en && rx_push && rx_full;
  wire rpop  = rx_en && rd_en && !rx_empty;

  assign rd_data = rx_empty ? '0 : head[DW-1:0];
  assign st_eof  = !rx_empty && head[DW];
  assign st_crc  = !rx_empty && head[DW+1];
  assign st_ovr  = !rx_empty && head[B_OVR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rwp <= '0; rrp <= '0; rcnt <= '0;
    end else if (!rx_en) begin
      rwp <= '0; rrp <= '0; rcnt <= '0;
    end else begin
      if (rpush) rwp <= (rwp == RAW'(RX_DEPTH-1)) ? '0 : rwp + 1'b1;
      if (rpop)  rrp <= (rrp == RAW'(RX_DEPTH-1)) ? '0 : rrp + 1'b1;
      rcnt <= rcnt + (RAW+1)'(rpush) - (RAW+1)'(rpop);
    end
  end

  always_ff @(posedge clk) begin
    if (rpush) rmem[rwp] <= {1'b0, rx_crc_err, rx_eof, rx_byte};
    if (rovr)  rmem[rlast][B_OVR] <= 1'b1;
  end

  p_tx_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> tx_empty);

  p_rx_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> rx_empty);

  p_tx_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> !tx_en || (tx_valid && $stable(tx_data)));

  p_rx_full_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && rx_full && !rd_en |=> rx_full);

  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty && rd_en && !rx_push |=> rx_empty);

  p_tx_full_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en && tx_full && !tx_ready |=> tx_full || !tx_en);
endmodule

// File: tb/framed_fifo_port_bench.sv
`timescale 1ns/1ps
module framed_fifo_port_bench;
  logic clk = 0, rst_n = 0;
  logic tx_en = 1, rx_en = 1, wr_en = 0, tx_ready = 0, rx_push = 0, rx_eof = 0, rx_crc_err = 0, rd_en = 0;
  logic [7:0] wr_data = 0, rx_byte = 0;
  logic wr_err, tx_valid, tx_full, tx_empty, rx_full, rx_empty, st_eof, st_crc, st_ovr;
  logic [7:0] tx_data, rd_data;

  framed_fifo_port u_framed_fifo_port (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0]  txq [$];
  logic [10:0] rxq [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n && tx_valid && tx_ready) begin
    if (txq.size() == 0) chk(0, "R1 unexpected byte", tx_data, 0);
    else begin
      logic [7:0] e;
      e = txq.pop_front();
      chk(tx_data == e, "R1 tx order", tx_data, e);
    end
  end

  task automatic tx_wr(input logic [7:0] b, input bit drop);
    @(negedge clk); wr_en = 1; wr_data = b;
    if (!drop && tx_en) txq.push_back(b);
    @(posedge clk); #1 wr_en = 0;
    chk(wr_err == drop, "R2 wr_err", wr_err, drop);
    if (drop) begin
      @(posedge clk); #1 chk(wr_err == 0, "R2 pulse width", wr_err, 0);
    end
  endtask

  task automatic rx_in(input logic [7:0] b, input bit eof, input bit crc);
    @(negedge clk); rx_push = 1; rx_byte = b; rx_eof = eof; rx_crc_err = crc;
    if (rx_en) begin
      if (rxq.size() < 12) rxq.push_back({1'b0, crc, eof, b});
      else rxq[rxq.size()-1][10] = 1'b1;
    end
    @(posedge clk); #1 rx_push = 0;
  endtask

  task automatic check_head(input string req);
    logic [10:0] e;
    e = (rxq.size() == 0) ? 11'd0 : rxq[0];
    chk(rd_data == e[7:0], {req, " rd_data"}, rd_data, e[7:0]);
    chk({st_ovr, st_crc, st_eof} == e[10:8], {req, " status tags"}, {st_ovr, st_crc, st_eof}, e[10:8]);
    chk(rx_empty == (rxq.size() == 0), {req, " rx_empty"}, rx_empty, rxq.size() == 0);
  endtask

  task automatic rx_rd(input string req);
    @(negedge clk); rd_en = 1; #1;
    check_head(req);
    @(posedge clk); #1 rd_en = 0;
    if (rxq.size() != 0) void'(rxq.pop_front());
  endtask

  initial begin
    #800000;
    chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(tx_empty && !tx_valid && !wr_err && !tx_full, "R9 tx reset", {tx_empty, tx_valid, wr_err}, 3'b100);
    chk(rx_empty && rd_data == 0 && !st_eof && !st_crc && !st_ovr, "R9 rx reset", rd_data, 0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < 8; i++) tx_wr(8'h10 + 8'(i), 0);
    #1 chk(tx_full, "R2 full at depth", tx_full, 1);
    tx_wr(8'hEE, 1);
    @(negedge clk); wr_en = 1; wr_data = 8'hDD; tx_ready = 1;
    @(posedge clk); #1 wr_en = 0; tx_ready = 0;
    chk(wr_err == 1, "R2 full write during take", wr_err, 1);
    @(negedge clk); tx_ready = 1;
    repeat (10) @(negedge clk);
    tx_ready = 0;
    chk(txq.size() == 0 && tx_empty, "R1 drained", txq.size(), 0);

    tx_wr(8'hA1, 0); tx_wr(8'hA2, 0);
    @(negedge clk); tx_en = 0;
    @(negedge clk);
    chk(tx_empty && !tx_valid, "R3 flushed", tx_empty, 1);
    txq.delete();
    tx_wr(8'hBB, 0);
    #1 chk(tx_empty, "R3 write ignored", tx_empty, 1);
    @(negedge clk); tx_en = 1;
    @(negedge clk); tx_ready = 1; #1;
    chk(!tx_valid, "R3 still empty", tx_valid, 0);
    tx_wr(8'h5A, 0); tx_wr(8'hA5, 0);
    repeat (3) @(negedge clk);
    tx_ready = 0;
    chk(txq.size() == 0, "R1 streaming", txq.size(), 0);

    rx_rd("R7 empty read");
    rx_in(8'h31, 0, 0); rx_in(8'h32, 0, 1); rx_in(8'h33, 1, 0);
    rx_rd("R4 R5 first"); rx_rd("R5 crc tag"); rx_rd("R5 eof tag");
    rx_rd("R7 empty after drain");

    for (int i = 0; i < 12; i++) rx_in(8'h40 + 8'(i), i == 11, 0);
    #1 chk(rx_full, "R6 full at depth", rx_full, 1);
    rx_in(8'hF0, 0, 0);
    rx_in(8'hF1, 0, 1);
    @(negedge clk); rx_push = 1; rx_byte = 8'hF2; rd_en = 1; #1;
    rxq[rxq.size()-1][10] = 1'b1;
    check_head("R6 read during overrun");
    @(posedge clk); #1 rx_push = 0; rd_en = 0;
    void'(rxq.pop_front());
    for (int i = 0; i < 11; i++) rx_rd("R6 R5 drain");
    rx_rd("R7 empty again");

    rx_in(8'h77, 1, 1); rx_in(8'h78, 0, 0);
    @(negedge clk); rx_en = 0;
    @(negedge clk);
    rxq.delete();
    check_head("R8 flushed");
    rx_in(8'h79, 0, 0);
    check_head("R8 push ignored");
    @(negedge clk); rx_en = 1;
    rx_in(8'h81, 1, 0);
    rx_rd("R8 R4 after re-enable");
    rx_rd("R7 final empty");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule